// File: doc/BRIEF.md
# USB Endpoint Stall Control Register

This block is a byte-wide control register through which application software forces up to four USB function endpoints into the stall state. Each endpoint has one stall bit. While that bit is set, the block raises a stall-request line that tells the packet engine to answer every host transaction on that endpoint with a STALL handshake. A fifth bit enables a global auto-clear mode. In that mode any stall bit drops by itself once the packet engine reports that a STALL handshake for that endpoint has gone out.

Several rules keep the stall bits consistent with protocol progress. The endpoint 0 bit clears by itself when a decoded setup command arrives. While setup-pending status is raised, software cannot set the endpoint 0 bit. When software and hardware touch the same bit in one cycle, the hardware clear takes precedence. The packet engine and the setup decoder are outside this block and appear only as event inputs. Software writes through a simple strobe port and reads back through a registered read path.

Top module: `usb_stall_ctl`

## Requirements
- R1: After an active-low reset every stall-request line is 0 and a read returns 0x00.
- R2: A write loads bit k (k = 0..3) as the stall bit of endpoint k and bit 4 as the auto-clear enable. The stall-request line k equals stall bit k from the cycle after the write.
- R3: Bits 7 to 5 always read as 0, whatever value was written to them.
- R4: A setup-received strobe clears the endpoint 0 stall bit in the next cycle, whether auto-clear is on or off.
- R5: While setup-pending is 1, a write with bit 0 = 1 leaves the endpoint 0 stall bit unchanged. The other bits of the same write still load, and a write with bit 0 = 0 still clears it.
- R6: With auto-clear enabled, a handshake-sent strobe carrying endpoint number k (2 bits) clears only stall bit k in the next cycle.
- R7: With auto-clear disabled, a handshake-sent strobe changes no stall bit.
- R8: When a write sets a bit that a hardware event clears in the same cycle, the bit ends up 0.
- R9: A read strobe captures the register value present at that clock edge onto the read data port, which holds that value until the next read strobe.
- R10: With no write and no clearing event, every stall bit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Register read strobe |
| regRdData | output | 8 | Registered read data |
| setupPend | input | 1 | Setup-pending status level |
| setupRcvd | input | 1 | One-cycle strobe: decoded setup command received |
| hsSent | input | 1 | One-cycle strobe: STALL handshake returned to host |
| hsEp | input | 2 | Endpoint number of the sent handshake |
| stallReq | output | 4 | Per-endpoint stall request to the packet engine |

## Verification
On every cycle the assertions check the following. The reserved read bits stay zero. A setup strobe or an auto-cleared handshake leaves its bit at 0. A blocked endpoint 0 write cannot raise the bit. A handshake with auto-clear off changes nothing. Quiet cycles hold state, and read data follows the register. Only the bench's scenarios can show that the write bit positions map to the right endpoints. They also show that the other bits of a blocked write still load, that the auto-enable bit itself reads back as written, and that long random mixes of writes, setups and handshakes keep the whole register equal to an independent model.

// File: rtl/usb_stall_pkg.sv
package usb_stall_pkg;
  localparam int unsigned EP_NUM   = 4;
  localparam int unsigned EP_SEL_W = $clog2(EP_NUM);
  localparam int unsigned REG_W    = 8;
  localparam int unsigned AUTO_POS = EP_NUM;
  localparam int unsigned USED_W   = EP_NUM + 1;

  typedef struct packed {
    logic              wrLoad;
    logic [EP_NUM-1:0] keepBit;
    logic [EP_NUM-1:0] hwClr;
  } stallStrobes_t;
endpackage

// File: rtl/usb_stall_ctrl.sv
module usb_stall_ctrl
  import usb_stall_pkg::*;
(
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  input  logic                setupPend,
  input  logic                setupRcvd,
  input  logic                hsSent,
  input  logic [EP_SEL_W-1:0] hsEp,
  input  logic                autoEn,
  output stallStrobes_t       strobes
);
  logic [EP_NUM-1:0] hsHit;

  always_comb begin
    strobes.wrLoad = regWrEn;
  end

  for (genvar i = 0; i < EP_NUM; i++) begin : g_ep
    assign hsHit[i] = hsSent && autoEn && (hsEp == EP_SEL_W'(i));
    if (i == 0) begin : g_ep0
      // endpoint 0: setup reception clears, setup-pending blocks a set
      assign strobes.hwClr[i]   = hsHit[i] | setupRcvd;
      assign strobes.keepBit[i] = setupPend & regWrData[i];
    end else begin : g_epN
      assign strobes.hwClr[i]   = hsHit[i];
      assign strobes.keepBit[i] = 1'b0;
    end
  end
endmodule

// File: rtl/usb_stall_dp.sv
module usb_stall_dp
  import usb_stall_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  stallStrobes_t     strobes,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              regRdEn,
  output logic [REG_W-1:0]  regRdData,
  output logic [EP_NUM-1:0] stallBits,
  output logic              autoEn
);
  localparam int unsigned PAD_W = REG_W - USED_W;

  for (genvar i = 0; i < EP_NUM; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       stallBits[i] <= 1'b0;
      else if (strobes.hwClr[i])                       stallBits[i] <= 1'b0;
      else if (strobes.wrLoad && !strobes.keepBit[i])  stallBits[i] <= regWrData[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               autoEn <= 1'b0;
    else if (strobes.wrLoad) autoEn <= regWrData[AUTO_POS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        regRdData <= '0;
    else if (regRdEn) regRdData <= {{PAD_W{1'b0}}, autoEn, stallBits};
  end
endmodule

// File: rtl/usb_stall_ctl.sv
module usb_stall_ctl
  import usb_stall_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  input  logic                regRdEn,
  output logic [REG_W-1:0]    regRdData,
  input  logic                setupPend,
  input  logic                setupRcvd,
  input  logic                hsSent,
  input  logic [EP_SEL_W-1:0] hsEp,
  output logic [EP_NUM-1:0]   stallReq
);
  stallStrobes_t     strobes;
  logic [EP_NUM-1:0] stallBits;
  logic              autoEn;

  usb_stall_ctrl i_ctrl (
    .regWrEn(regWrEn), .regWrData(regWrData), .setupPend(setupPend),
    .setupRcvd(setupRcvd), .hsSent(hsSent), .hsEp(hsEp),
    .autoEn(autoEn), .strobes(strobes)
  );

  usb_stall_dp i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .stallBits(stallBits),
    .autoEn(autoEn)
  );

  assign stallReq = stallBits;
endmodule

// File: rtl/usb_stall_ctl_chk.sv
module usb_stall_ctl_chk
  import usb_stall_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [REG_W-1:0]    regWrData,
  input logic                regRdEn,
  input logic [REG_W-1:0]    regRdData,
  input logic                setupPend,
  input logic                setupRcvd,
  input logic                hsSent,
  input logic [EP_SEL_W-1:0] hsEp,
  input logic [EP_NUM-1:0]   stallReq,
  input logic                autoEn
);
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[REG_W-1:USED_W] == '0);

  assert_setup_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    setupRcvd |=> !stallReq[0]);

  assert_pending_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && setupPend && !stallReq[0]) |=> !stallReq[0]);

  for (genvar k = 0; k < EP_NUM; k++) begin : g_chk
    assert_auto_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
      (hsSent && autoEn && hsEp == EP_SEL_W'(k)) |=> !stallReq[k]);
    assert_hw_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regWrData[k] && hsSent && autoEn && hsEp == EP_SEL_W'(k)) |=> !stallReq[k]);
  end

  assert_no_auto_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hsSent && !autoEn && !regWrEn && !setupRcvd) |=> $stable(stallReq));

  assert_read_path_R9: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdData[USED_W-1:0] == $past({autoEn, stallReq}));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && !setupRcvd && !hsSent) |=> $stable(stallReq));
endmodule

bind usb_stall_ctl usb_stall_ctl_chk i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdEn(regRdEn), .regRdData(regRdData), .setupPend(setupPend),
  .setupRcvd(setupRcvd), .hsSent(hsSent), .hsEp(hsEp),
  .stallReq(stallReq), .autoEn(autoEn)
);

// File: tb/test_usb_stall_ctl.sv
`timescale 1ns/1ps
module test_usb_stall_ctl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic       regRdEn = 1'b0;
  logic [7:0] regRdData;
  logic       setupPend = 1'b0;
  logic       setupRcvd = 1'b0;
  logic       hsSent = 1'b0;
  logic [1:0] hsEp = '0;
  logic [3:0] stallReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  logic [4:0] expReg = '0;
  logic [7:0] expRd  = '0;

  always #2 clk = ~clk;

  usb_stall_ctl i_usb_stall_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .setupPend(setupPend),
    .setupRcvd(setupRcvd), .hsSent(hsSent), .hsEp(hsEp), .stallReq(stallReq)
  );

  // model: bits 3..0 = endpoint stall, bit 4 = auto-clear enable
  function automatic logic [4:0] nextReg(logic [4:0] cur, logic we, logic [7:0] wd,
                                         logic pend, logic setup, logic hs, logic [1:0] ep);
    logic [4:0] n = cur;
    if (we) begin
      n[4] = wd[4];
      for (int i = 0; i < 4; i++) begin
        if (!(i == 0 && pend && wd[0])) n[i] = wd[i];
      end
    end
    if (setup) n[0] = 1'b0;
    if (hs && cur[4]) n[ep] = 1'b0;
    return n;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic we, logic [7:0] wd, logic re,
                      logic pend, logic setup, logic hs, logic [1:0] ep);
    regWrEn = we; regWrData = wd; regRdEn = re;
    setupPend = pend; setupRcvd = setup; hsSent = hs; hsEp = ep;
    if (re) expRd = {3'b000, expReg};
    expReg = nextReg(expReg, we, wd, pend, setup, hs, ep);
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0; setupRcvd = 1'b0; hsSent = 1'b0;
    check({tag, " stallReq"}, {4'h0, stallReq}, {4'h0, expReg[3:0]});
    check({tag, " readData"}, regRdData, expRd);
  endtask

  task automatic readBack(string tag);
    step(tag, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5813));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset stallReq", {4'h0, stallReq}, 8'h00);
    readBack("R1 reset read");

    step("R2 write map", 1'b1, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    check("R2 ep0 and ep2 set", {4'h0, stallReq}, 8'h05);
    readBack("R2 readback");
    step("R3 reserved write", 1'b1, 8'hFA, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    readBack("R3 reserved read");
    check("R3 reserved bits zero", regRdData, 8'h1A);

    step("R4 setup clears ep0", 1'b1, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    step("R4 setup", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0);
    check("R4 ep0 cleared, auto off", {4'h0, stallReq}, 8'h0E);

    step("R5 pending set", 1'b1, 8'h07, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
    check("R5 ep0 blocked, others load", {4'h0, stallReq}, 8'h06);
    step("R5 write ep0", 1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    step("R5 pending clear", 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
    check("R5 write 0 clears", {4'h0, stallReq}, 8'h00);

    step("R7 arm", 1'b1, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    step("R7 hs auto off", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2);
    check("R7 no change", {4'h0, stallReq}, 8'h0F);

    step("R6 enable auto", 1'b1, 8'h1F, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    step("R6 hs ep2", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2);
    check("R6 only ep2 cleared", {4'h0, stallReq}, 8'h0B);
    step("R6 hs ep3", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3);
    check("R6 ep3 cleared", {4'h0, stallReq}, 8'h03);

    step("R8 write vs hs", 1'b1, 8'h1F, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1);
    check("R8 hw clear wins ep1", {4'h0, stallReq}, 8'h0D);
    step("R8 write vs setup", 1'b1, 8'h1F, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0);
    check("R8 hw clear wins ep0", {4'h0, stallReq}, 8'h0E);

    step("R9 read", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    check("R9 read value", regRdData, 8'h1E);
    step("R9 write no read", 1'b1, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    check("R9 read data held", regRdData, 8'h1E);

    step("R10 idle", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
    check("R10 hold", {4'h0, stallReq}, 8'h03);

    for (int n = 0; n < 3000; n++) begin
      logic we, re, pend, setup, hs;
      logic [7:0] wd;
      logic [1:0] ep;
      string tag;
      we = ($urandom % 4) == 0;
      wd = 8'($urandom);
      re = ($urandom % 3) == 0;
      pend = ($urandom % 3) == 0;
      setup = ($urandom % 8) == 0;
      hs = ($urandom % 4) == 0;
      ep = 2'($urandom);
      if (setup)          tag = "R4 random";
      else if (hs)        tag = expReg[4] ? "R6 random" : "R7 random";
      else if (we && pend) tag = "R5 random";
      else if (we)        tag = "R2 random";
      else                tag = "R10 random";
      step(tag, we, wd, re, pend, setup, hs, ep);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule